// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Unit

This block watches the instruction fetch address and raises a breakpoint when the address equals one of a bank of programmable comparators. A debugger programs it through a 32-bit register bus. The bus reaches a control word at byte offset 0 and one comparator word per slot at offsets 8, 12, 16 and upward. A single global enable gates the whole bank, and each slot has its own enable bit.

A parameter selects one of two comparator encodings. The halfword encoding covers only the low 512 MB of the address space. It holds a word address plus a two-bit code that chooses the lower halfword, the upper halfword or both. The full-address encoding holds address bits 31:1 directly. The hit is registered and appears one clock after the fetch that caused it. When several slots match, a one-hot vector identifies the lowest-numbered matching slot.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the global enable is 0. The control word reads back as follows: the encoding revision is in bits 31:28 (0 for halfword, 1 for full address), the slot count is split across bits 14:12 (upper three bits) and bits 7:4 (lower four bits), bits 11:8 read 0, and bit 0 is the global enable.
- R2: A write to the control word updates the global enable from wdata bit 0 only when wdata bit 1 is 1. A write with bit 1 equal to 0 leaves the enable unchanged.
- R3: In the halfword encoding a slot word holds a code in bits 31:30, address bits 28:2 in bits 28:2 and the slot enable in bit 0, and bits 29 and 1 read 0. In the full encoding bits 31:1 hold address bits 31:1 and bit 0 is the slot enable. Writing 0x4800_09A5 reads back 0x4800_09A5 in both encodings.
- R4: In the halfword encoding, code 01 matches a fetch whose bits 1:0 are 00, code 10 matches bits 1:0 equal to 10, and code 11 matches both. A fetch with bits 1:0 equal to 01 or 11 never matches.
- R5: In the halfword encoding, code 00 never produces a hit.
- R6: In the halfword encoding, a fetch at or above 0x2000_0000 never produces a hit.
- R7: In the full encoding, a slot matches when fetch bits 31:1 equal its stored bits 31:1.
- R8: A hit needs a valid fetch, the global enable and the slot enable all at once.
- R9: The hit outputs reflect the fetch sampled at the previous rising clock edge. A cycle with no valid fetch yields no hit on the next cycle.
- R10: The hit vector has at most one bit set, which is the lowest-numbered matching slot, and bp_hit is 1 exactly when the vector is nonzero.
- R11: Slot i sits at byte offset 8 + 4*i. Any other offset reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| bp_hit | output | 1 | Registered breakpoint hit |
| bp_hit_vec | output | NUM_CMP | Registered one-hot hit vector, lowest slot wins |

## Verification
Some properties are checked on every cycle. The hit vector must stay one-hot and agree with bp_hit. An idle fetch or a cleared global enable must be followed by no hit. A keyless control write must leave the enable unchanged. In the halfword build, a fetch above 512 MB must never hit. The bench scenarios cover what needs programmed slot contents: halfword code selection, the inert code 00, full-address matching that ignores bit 0, priority between duplicate slots, readback masking and the address map. A behavioural model, compared every clock against both a halfword and a full-address instance, also covers these.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;
   localparam int WORD_W      = 32;
   localparam int REV_HALFWORD = 0;
   localparam int REV_FULL     = 1;
   localparam int SLOT_BASE   = 8;
   localparam int SLOT_STRIDE = 4;
   localparam int KEY_BIT     = 1;
   localparam int EN_BIT      = 0;
   localparam int MAX_SLOTS   = 127;

   // Control word image: revision, split slot count, enable.
   function automatic logic [WORD_W-1:0] ctrl_image(input int rev, input int nslot,
                                                    input logic en);
      logic [WORD_W-1:0] v;
      logic [6:0]        cnt;
      cnt       = 7'(nslot);
      v         = '0;
      v[31:28]  = 4'(rev);
      v[14:12]  = cnt[6:4];
      v[7:4]    = cnt[3:0];
      v[EN_BIT] = en;
      return v;
   endfunction
endpackage

// File: rtl/bkpt_ctrl.sv
`timescale 1ns/1ps
module bkpt_ctrl
   import bkpt_pkg::*;
#(
   parameter int NUM_CMP = 4,
   parameter int REV     = REV_HALFWORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wdata,
   output logic              glob_en,
   output logic [WORD_W-1:0] rd_val
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[WORD_W-1:2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         glob_en <= 1'b0;
      else if (wr_en && wdata[KEY_BIT])   glob_en <= wdata[EN_BIT];
   end

   assign rd_val = ctrl_image(REV, NUM_CMP, glob_en);
endmodule

// File: rtl/bkpt_slot.sv
`timescale 1ns/1ps
module bkpt_slot
   import bkpt_pkg::*;
#(
   parameter int REV = REV_HALFWORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] fetch_addr,
   output logic [WORD_W-1:0] rd_val,
   output logic              match
);
   generate
      if (REV == REV_HALFWORD) begin : g_half
         logic [1:0]  hw_code;
         logic [26:0] word_a;
         logic        slot_en;
         logic        lo_ok, hi_ok;
         logic        unused_wbits;
         assign unused_wbits = ^{wdata[29], wdata[1]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hw_code <= '0;
               word_a  <= '0;
               slot_en <= 1'b0;
            end else if (wr_en) begin
               hw_code <= wdata[31:30];
               word_a  <= wdata[28:2];
               slot_en <= wdata[EN_BIT];
            end
         end

         assign rd_val = {hw_code, 1'b0, word_a, 1'b0, slot_en};
         assign lo_ok  = hw_code[0] && (fetch_addr[1:0] == 2'b00);
         assign hi_ok  = hw_code[1] && (fetch_addr[1:0] == 2'b10);
         assign match  = slot_en && (fetch_addr[31:29] == 3'b000) &&
                         (fetch_addr[28:2] == word_a) && (lo_ok || hi_ok);
      end else begin : g_full
         logic [30:0] half_a;
         logic        slot_en;
         logic        unused_abit;
         assign unused_abit = fetch_addr[0];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               half_a  <= '0;
               slot_en <= 1'b0;
            end else if (wr_en) begin
               half_a  <= wdata[31:1];
               slot_en <= wdata[EN_BIT];
            end
         end

         assign rd_val = {half_a, slot_en};
         assign match  = slot_en && (fetch_addr[31:1] == half_a);
      end
   endgenerate
endmodule

// File: rtl/bkpt_prio.sv
`timescale 1ns/1ps
module bkpt_prio #(
   parameter int NUM_CMP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CMP-1:0] req,
   output logic [NUM_CMP-1:0] hit_vec,
   output logic               hit
);
   logic [NUM_CMP-1:0] lowest;
   // Isolate the least significant set bit.
   assign lowest = req & (~req + NUM_CMP'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vec <= '0;
         hit     <= 1'b0;
      end else begin
         hit_vec <= lowest;
         hit     <= |req;
      end
   end
endmodule

// File: rtl/bkpt_unit.sv
`timescale 1ns/1ps
module bkpt_unit
   import bkpt_pkg::*;
#(
   parameter int NUM_CMP = 6,
   parameter int REV     = REV_HALFWORD,
   parameter int REG_AW  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               fetch_valid,
   input  logic [31:0]        fetch_addr,
   output logic               bp_hit,
   output logic [NUM_CMP-1:0] bp_hit_vec
);
   localparam int MAP_END = SLOT_BASE + SLOT_STRIDE * NUM_CMP;

   generate
      if (NUM_CMP < 1 || NUM_CMP > MAX_SLOTS) begin : g_bad_count
         $error("bkpt_unit: NUM_CMP out of range");
      end
      if (REV != REV_HALFWORD && REV != REV_FULL) begin : g_bad_rev
         $error("bkpt_unit: REV must be 0 or 1");
      end
      if (MAP_END > (1 << REG_AW)) begin : g_bad_aw
         $error("bkpt_unit: REG_AW too small for slot map");
      end
   endgenerate

   logic               ctrl_sel;
   logic               glob_en;
   logic [31:0]        ctrl_rd;
   logic [NUM_CMP-1:0] slot_sel;
   logic [NUM_CMP-1:0] slot_match;
   logic [NUM_CMP-1:0] slot_req;
   logic [31:0]        slot_rd [NUM_CMP];

   assign ctrl_sel = (reg_addr == '0);

   bkpt_ctrl #(.NUM_CMP(NUM_CMP), .REV(REV)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we && ctrl_sel),
      .wdata   (reg_wdata),
      .glob_en (glob_en),
      .rd_val  (ctrl_rd)
   );

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
         assign slot_sel[i] = (reg_addr == REG_AW'(SLOT_BASE + SLOT_STRIDE * i));
         bkpt_slot #(.REV(REV)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_we && slot_sel[i]),
            .wdata      (reg_wdata),
            .fetch_addr (fetch_addr),
            .rd_val     (slot_rd[i]),
            .match      (slot_match[i])
         );
      end
   endgenerate

   assign slot_req = (fetch_valid && glob_en) ? slot_match : '0;

   bkpt_prio #(.NUM_CMP(NUM_CMP)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (slot_req),
      .hit_vec (bp_hit_vec),
      .hit     (bp_hit)
   );

   always_comb begin
      reg_rdata = ctrl_sel ? ctrl_rd : 32'h0;
      for (int i = 0; i < NUM_CMP; i++) begin
         if (slot_sel[i]) reg_rdata = reg_rdata | slot_rd[i];
      end
   end
endmodule

// File: rtl/bkpt_unit_chk.sv
`timescale 1ns/1ps
module bkpt_unit_chk #(
   parameter int NUM_CMP = 6,
   parameter int REV     = 0,
   parameter int REG_AW  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [REG_AW-1:0]  reg_addr,
   input logic               wkey,
   input logic               fetch_valid,
   input logic [2:0]         fetch_hi,
   input logic               glob_en,
   input logic               bp_hit,
   input logic [NUM_CMP-1:0] bp_hit_vec
);
   a_r1_enable_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !glob_en);

   a_r2_keyless_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == '0 && !wkey) |=> $stable(glob_en));

   a_r8_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !bp_hit);

   a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> !bp_hit);

   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bp_hit_vec));

   a_r10_flag_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit == (bp_hit_vec != '0));

   generate
      if (REV == 0) begin : g_half_chk
         a_r6_high_region_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_valid && fetch_hi != 3'b000) |=> !bp_hit);
      end else begin : g_full_chk
         logic unused_hi;
         assign unused_hi = ^fetch_hi;
      end
   endgenerate
endmodule

bind bkpt_unit bkpt_unit_chk #(.NUM_CMP(NUM_CMP), .REV(REV), .REG_AW(REG_AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .wkey        (reg_wdata[1]),
   .fetch_valid (fetch_valid),
   .fetch_hi    (fetch_addr[31:29]),
   .glob_en     (glob_en),
   .bp_hit      (bp_hit),
   .bp_hit_vec  (bp_hit_vec)
);

// File: tb/bkpt_unit_tb.sv
`timescale 1ns/1ps
module bkpt_unit_tb;
   localparam int NC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          fetch_valid = 1'b0;
   logic [31:0]   fetch_addr = '0;
   logic [31:0]   rd0, rd1;
   logic          hit0, hit1;
   logic [NC-1:0] vec0, vec1;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bkpt_unit #(.NUM_CMP(NC), .REV(0), .REG_AW(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd0), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .bp_hit(hit0), .bp_hit_vec(vec0));

   bkpt_unit #(.NUM_CMP(NC), .REV(1), .REG_AW(8)) u_dut_full (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rd1), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .bp_hit(hit1), .bp_hit_vec(vec1));

   // ---------------- behavioural reference model ----------------
   logic [31:0]   mreg [2][NC];
   logic          men  [2];
   logic [NC-1:0] mexp [2];

   function automatic bit mdl_hit(int rv, int i, logic [31:0] a);
      logic [31:0] r;
      r = mreg[rv][i];
      if (!r[0]) return 0;
      if (rv == 1) return (a | 32'h1) == (r | 32'h1);
      if (a >= 32'h2000_0000) return 0;
      if ((a & 32'hFFFF_FFFC) != (r & 32'h1FFF_FFFC)) return 0;
      if (a[1:0] == 2'b00) return r[30];
      if (a[1:0] == 2'b10) return r[31];
      return 0;
   endfunction

   function automatic logic [NC-1:0] mdl_pick(int rv, logic [31:0] a);
      if (!men[rv]) return '0;
      for (int i = 0; i < NC; i++) if (mdl_hit(rv, i, a)) return NC'(1) << i;
      return '0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int rv = 0; rv < 2; rv++) begin
            men[rv] = 1'b0;
            mexp[rv] = '0;
            for (int i = 0; i < NC; i++) mreg[rv][i] = '0;
         end
      end else begin
         for (int rv = 0; rv < 2; rv++)
            mexp[rv] = fetch_valid ? mdl_pick(rv, fetch_addr) : '0;
         if (reg_we) begin
            if (reg_addr == 0) begin
               if (reg_wdata[1]) begin men[0] = reg_wdata[0]; men[1] = reg_wdata[0]; end
            end else if (reg_addr >= 8 && reg_addr[1:0] == 0 && (reg_addr - 8) / 4 < NC) begin
               mreg[0][(reg_addr - 8) / 4] = reg_wdata & 32'hDFFF_FFFD;
               mreg[1][(reg_addr - 8) / 4] = reg_wdata;
            end
         end
      end
   end

   // R9 R10: outputs compared against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (vec0 !== mexp[0] || hit0 !== (mexp[0] != 0)) begin
            errors++;
            $display("FAIL R9 per-cycle halfword: actual %h/%b expected %h", vec0, hit0, mexp[0]);
         end
         checks++;
         if (vec1 !== mexp[1] || hit1 !== (mexp[1] != 0)) begin
            errors++;
            $display("FAIL R9 per-cycle full: actual %h/%b expected %h", vec1, hit1, mexp[1]);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(string req, logic [7:0] a, logic [31:0] e0, logic [31:0] e1);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk({req, " halfword read"}, rd0, e0);
      chk({req, " full read"}, rd1, e1);
   endtask

   task automatic fetch(string req, bit v, logic [31:0] a,
                        logic [NC-1:0] e0, logic [NC-1:0] e1);
      @(negedge clk);
      fetch_valid = v; fetch_addr = a;
      @(negedge clk);
      fetch_valid = 1'b0;
      chk({req, " halfword vec"}, 32'(vec0), 32'(e0));
      chk({req, " full vec"},     32'(vec1), 32'(e1));
      chk({req, " halfword flag"}, 32'(hit0), 32'(e0 != 0));
      @(negedge clk);
      chk("R9 halfword clears next cycle", 32'(vec0), 32'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset image, count 20 -> upper 1, lower 4
      rd("R1 ctrl", 8'h00, 32'h0000_1040, 32'h1000_1040);
      chk("R1 no hit at reset", 32'(hit0), 32'h0);

      // R11: unmapped offsets
      wr(8'h04, 32'hFFFF_FFFF);
      rd("R11 gap offset", 8'h04, 32'h0, 32'h0);
      rd("R11 beyond map", 8'(8 + 4 * NC), 32'h0, 32'h0);

      // R3: layout and masking
      wr(8'h08, 32'hFFFF_FFFF);
      rd("R3 mask", 8'h08, 32'hDFFF_FFFD, 32'hFFFF_FFFF);
      wr(8'h08, 32'h4800_09A5);
      rd("R3 example word", 8'h08, 32'h4800_09A5, 32'h4800_09A5);

      wr(8'h0C, 32'h8000_0101);
      wr(8'h10, 32'hC000_0201);
      wr(8'h14, 32'h0000_0301);
      wr(8'h18, 32'h4000_0400);
      wr(8'h1C, 32'hC000_0201);
      rd("R11 slot 5 offset", 8'h1C, 32'hC000_0201, 32'hC000_0201);
      rd("R11 slot 1 offset", 8'h0C, 32'h8000_0101, 32'h8000_0101);

      // R8: enable still off
      fetch("R8 global off", 1, 32'h0800_09A4, '0, '0);

      // R2: keyless write ignored, keyed write applies
      wr(8'h00, 32'h0000_0001);
      rd("R2 keyless", 8'h00, 32'h0000_1040, 32'h1000_1040);
      wr(8'h00, 32'h0000_0003);
      rd("R2 keyed", 8'h00, 32'h0000_1041, 32'h1000_1041);
      wr(8'h00, 32'h0000_0000);
      rd("R2 keyless clear", 8'h00, 32'h0000_1041, 32'h1000_1041);

      // R4 halfword codes
      fetch("R4 lower code", 1, 32'h0800_09A4, NC'(1), '0);
      fetch("R4 lower code other half", 1, 32'h0800_09A6, '0, '0);
      fetch("R4 upper code", 1, 32'h0000_0102, NC'(2), '0);
      fetch("R4 upper code lower half", 1, 32'h0000_0100, '0, '0);
      fetch("R4 odd address", 1, 32'h0000_0101, '0, '0);
      // R10: slots 2 and 5 both match, slot 2 wins
      fetch("R4 R10 both code low", 1, 32'h0000_0200, NC'(4), '0);
      fetch("R4 R10 both code high", 1, 32'h0000_0202, NC'(4), '0);
      // R5 and R7
      fetch("R5 R7 code zero", 1, 32'h0000_0300, '0, NC'(8));
      // R8 slot disabled
      fetch("R8 slot off", 1, 32'h0000_0400, '0, '0);
      // R6 high region
      fetch("R6 aliased high", 1, 32'h2800_09A4, '0, '0);
      fetch("R6 R7 full only", 1, 32'h4800_09A4, '0, NC'(1));
      fetch("R7 bit0 ignored", 1, 32'h4800_09A5, '0, NC'(1));
      fetch("R7 R10 full priority", 1, 32'hC000_0200, '0, NC'(4));
      // R8 fetch not valid
      fetch("R8 invalid fetch", 0, 32'h0800_09A4, '0, '0);
      // R8 global disable
      wr(8'h00, 32'h0000_0002);
      fetch("R8 global cleared", 1, 32'h0800_09A4, '0, '0);

      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule